// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, for each received Ethernet frame, whether the frame is kept or dropped, judging only by its 48-bit destination address. It compares the address against a bank of exact-match slots. It also folds the address into a 6-bit index that selects one bin of a 64-bin multicast table. Mode controls add promiscuous capture, accept-all-multicast, broadcast rejection and a gate on the hash path.

Software programs the block through a single-cycle register write port. Each slot has two words. The hash table is split into two 32-bit words, and one word holds the mode bits. The receive path presents the destination address together with a valid strobe. On the next clock edge the block returns a decision strobe, an accept flag and a 3-bit code that says which rule matched.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, no decision is pending, every slot is cleared and disabled, both hash words are zero, and all mode bits are off. With reset values a zero address is dropped, and a multicast frame misses the hash even when the hash path is enabled.
- R2: A decision appears on `dec_valid_o`, `accept_o` and `match_o` exactly one clock after `frame_valid_i` is sampled high. In any cycle that follows a cycle without `frame_valid_i`, `dec_valid_o` is low.
- R3: Slot n has its low word at config address 2n and its high word at 2n+1. The low word holds address bytes 0..3, with byte 0 in bits 7:0. The high word holds byte 4 in bits 7:0 and byte 5 in bits 15:8. On `dst_addr_i`, byte 0 sits in bits 7:0. An enabled slot whose 48 bits equal the destination gives match code 1 (exact).
- R4: A write to a slot's low word disables that slot. A write to its high word enables it again. The stored address is kept across both writes.
- R5: The hash index is the XOR fold of address bit i into index bit (i mod 6), with bit i taken as bit (i mod 8) of byte (i div 8). Bytes are taken in order 0 to 5, least significant bit first.
- R6: An index below 32 selects that bit of the low hash word, at config address 2*NUM_SLOTS. An index of 32 or more selects bit (index-32) of the high hash word, at address 2*NUM_SLOTS+1.
- R7: The hash table is used only for multicast frames (bit 0 of byte 0 set) that are not broadcast, and only when mode bit 3 (hash enable) is set. The mode word is at address 2*NUM_SLOTS+2. A hash hit gives code 2.
- R8: Mode bit 1 (all-multicast) accepts every non-broadcast multicast frame with code 2, whatever the table holds and whatever the hash-enable bit is.
- R9: A broadcast frame (all 48 bits one) is accepted with code 3 unless mode bit 2 (broadcast reject) is set.
- R10: Mode bit 0 (promiscuous) accepts every frame. The frame gets code 4 when no other rule matched.
- R11: The rules are tried in the order exact, broadcast, hash, promiscuous. `accept_o` is high exactly when the code is not 0, and code 0 means the frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 5 | Config word address |
| cfg_wdata_i | input | 32 | Config write data |
| frame_valid_i | input | 1 | Destination address valid |
| dst_addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid_o | output | 1 | Decision valid |
| accept_o | output | 1 | Frame accepted |
| match_o | output | 3 | Match code: 0 none, 1 exact, 2 hash, 3 broadcast, 4 promiscuous |

## Verification
The assertions assume that the config port and the frame port are driven from the same clock domain. They also assume that a config write and a frame strobe landing on the same edge are resolved by letting the frame see the configuration that was in force before that write. The stimulus never overlaps the two. It always completes a write before the next frame is presented, so every expected code depends on one stable configuration. The assertions also assume that `dst_addr_i` is stable while `frame_valid_i` is high. The bench holds the address for the whole strobe cycle.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int MAC_W   = 48;
  localparam int HASH_W  = 6;
  localparam int TBL_BITS = 1 << HASH_W;

  typedef enum logic [2:0] {
    MT_NONE    = 3'd0,
    MT_EXACT   = 3'd1,
    MT_HASH    = 3'd2,
    MT_BCAST   = 3'd3,
    MT_PROMISC = 3'd4
  } match_e;

  localparam int MODE_PROMISC  = 0;
  localparam int MODE_ALLMULTI = 1;
  localparam int MODE_BCASTREJ = 2;
  localparam int MODE_HASHEN   = 3;
endpackage

// File: rtl/rxaf_cfg.sv
module rxaf_cfg
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CFG_AW    = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [CFG_AW-1:0]               addr_i,
  input  logic [31:0]                     wdata_i,
  output logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr_o,
  output logic [NUM_SLOTS-1:0]            slot_en_o,
  output logic [TBL_BITS-1:0]             hash_tbl_o,
  output logic                            promisc_o,
  output logic                            all_multi_o,
  output logic                            bcast_rej_o,
  output logic                            hash_en_o
);
  localparam int HASH_LO_A = 2 * NUM_SLOTS;
  localparam int HASH_HI_A = HASH_LO_A + 1;
  localparam int MODE_A    = HASH_LO_A + 2;

  logic [3:0] mode_q;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_addr_o[n] <= '0;
        slot_en_o[n]   <= 1'b0;
      end else if (we_i && addr_i == CFG_AW'(2 * n)) begin
        slot_addr_o[n][31:0] <= wdata_i;
        slot_en_o[n]         <= 1'b0;
      end else if (we_i && addr_i == CFG_AW'(2 * n + 1)) begin
        slot_addr_o[n][MAC_W-1:32] <= wdata_i[MAC_W-33:0];
        slot_en_o[n]               <= 1'b1;
      end
    end

    AST_LOW_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == CFG_AW'(2 * n)) |=> !slot_en_o[n]);  // R4
    AST_HIGH_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == CFG_AW'(2 * n + 1)) |=> slot_en_o[n]);  // R4
    AST_LOW_KEEPS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == CFG_AW'(2 * n)) |=> $stable(slot_addr_o[n][MAC_W-1:32]));  // R4
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hash_tbl_o <= '0;
      mode_q     <= '0;
    end else if (we_i) begin
      case (addr_i)
        CFG_AW'(HASH_LO_A): hash_tbl_o[31:0]          <= wdata_i;
        CFG_AW'(HASH_HI_A): hash_tbl_o[TBL_BITS-1:32] <= wdata_i;
        CFG_AW'(MODE_A):    mode_q                    <= wdata_i[3:0];
        default: ;
      endcase
    end
  end

  assign promisc_o   = mode_q[MODE_PROMISC];
  assign all_multi_o = mode_q[MODE_ALLMULTI];
  assign bcast_rej_o = mode_q[MODE_BCASTREJ];
  assign hash_en_o   = mode_q[MODE_HASHEN];
endmodule

// File: rtl/rxaf_exact.sv
module rxaf_exact
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic [MAC_W-1:0]                addr_i,
  input  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr_i,
  input  logic [NUM_SLOTS-1:0]            slot_en_i,
  output logic                            hit_o
);
  logic [NUM_SLOTS-1:0] eq;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_cmp
    assign eq[n] = slot_en_i[n] && (slot_addr_i[n] == addr_i);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
  import rxaf_pkg::*;
(
  input  logic [MAC_W-1:0]    addr_i,
  input  logic [TBL_BITS-1:0] tbl_i,
  output logic [HASH_W-1:0]   idx_o,
  output logic                hit_o
);
  // address bit i folds into index bit i mod HASH_W
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < MAC_W; i++) begin
      idx_o[i % HASH_W] = idx_o[i % HASH_W] ^ addr_i[i];
    end
  end

  assign hit_o = tbl_i[idx_o];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CFG_AW    = $clog2(2 * NUM_SLOTS + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              frame_valid_i,
  input  logic [47:0]       dst_addr_i,
  output logic              dec_valid_o,
  output logic              accept_o,
  output logic [2:0]        match_o
);
  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0]            slot_en;
  logic [TBL_BITS-1:0]             hash_tbl;
  logic promisc, all_multi, bcast_rej, hash_en;
  logic exact_hit, tbl_hit;
  logic [HASH_W-1:0] hash_idx;
  logic is_mcast, is_bcast, hash_hit, bcast_hit, acc_d;
  match_e code_d;

  rxaf_cfg #(.NUM_SLOTS(NUM_SLOTS), .CFG_AW(CFG_AW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .slot_addr_o (slot_addr),
    .slot_en_o   (slot_en),
    .hash_tbl_o  (hash_tbl),
    .promisc_o   (promisc),
    .all_multi_o (all_multi),
    .bcast_rej_o (bcast_rej),
    .hash_en_o   (hash_en)
  );

  rxaf_exact #(.NUM_SLOTS(NUM_SLOTS)) u_exact (
    .addr_i      (dst_addr_i),
    .slot_addr_i (slot_addr),
    .slot_en_i   (slot_en),
    .hit_o       (exact_hit)
  );

  rxaf_hash u_hash (
    .addr_i (dst_addr_i),
    .tbl_i  (hash_tbl),
    .idx_o  (hash_idx),
    .hit_o  (tbl_hit)
  );

  assign is_mcast  = dst_addr_i[0];
  assign is_bcast  = &dst_addr_i;
  assign bcast_hit = is_bcast && !bcast_rej;
  assign hash_hit  = is_mcast && !is_bcast && (all_multi || (hash_en && tbl_hit));
  assign acc_d     = exact_hit || bcast_hit || hash_hit || promisc;

  always_comb begin
    if (exact_hit)      code_d = MT_EXACT;
    else if (bcast_hit) code_d = MT_BCAST;
    else if (hash_hit)  code_d = MT_HASH;
    else if (promisc)   code_d = MT_PROMISC;
    else                code_d = MT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      match_o     <= MT_NONE;
    end else begin
      dec_valid_o <= frame_valid_i;
      if (frame_valid_i) begin
        accept_o <= acc_d;
        match_o  <= code_d;
      end
    end
  end

  AST_DEC_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> dec_valid_o);  // R2
  AST_DEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !dec_valid_o);  // R2
  AST_ACCEPT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (accept_o == (match_o != MT_NONE)));  // R11
  AST_PROMISC_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && promisc) |=> accept_o);  // R10
  AST_UCAST_NO_HASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !dst_addr_i[0]) |=> match_o != MT_HASH);  // R7
  AST_BCAST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && (&dst_addr_i) && bcast_rej && !promisc && !exact_hit) |=> !accept_o);  // R9
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fv = 1'b0;
  logic [47:0] dst = '0;
  logic        dec_valid, accept;
  logic [2:0]  match;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rx_addr_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .frame_valid_i(fv), .dst_addr_i(dst),
    .dec_valid_o(dec_valid), .accept_o(accept), .match_o(match)
  );

  localparam logic [47:0] STA   = 48'h0A0B_0C0D_0E02;  // unicast, slot 0
  localparam logic [47:0] MC_X  = 48'h0000_0000_0005;  // slot 3, hash 5
  localparam logic [47:0] MC_LO = 48'h0000_0000_0001;  // hash 1 -> low bit 1
  localparam logic [47:0] MC_HI = 48'h0000_0000_0021;  // hash 33 -> high bit 1
  localparam logic [47:0] MC_NO = 48'h0000_0000_0003;  // hash 3 -> clear
  localparam logic [47:0] MC_WR = 48'h0000_0000_0101;  // byte1 bit0 -> idx 2, hash 5
  localparam logic [47:0] BC    = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] UC_X  = 48'h0A0B_0C0D_0E04;

  // {addr, accept, code}
  localparam logic [51:0] VEC [8] = '{
    {STA,   1'b1, 3'd1},   // R3
    {MC_X,  1'b1, 3'd1},   // R3
    {MC_LO, 1'b1, 3'd2},   // R5 R6 low word
    {MC_HI, 1'b1, 3'd2},   // R5 R6 high word
    {MC_NO, 1'b0, 3'd0},   // R5
    {MC_WR, 1'b0, 3'd0},   // R5 wrap
    {BC,    1'b1, 3'd3},   // R9
    {UC_X,  1'b0, 3'd0}    // R11
  };

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [47:0] a, input logic exp_acc,
                      input logic [2:0] exp_code, input string tag);
    @(negedge clk);
    fv = 1'b1; dst = a;
    @(negedge clk);
    fv = 1'b0;
    checks++;
    if (dec_valid !== 1'b1 || accept !== exp_acc || match !== exp_code) begin
      fails++;
      $display("FAIL %s addr=%h got v=%b acc=%b code=%0d exp v=1 acc=%b code=%0d",
               tag, a, dec_valid, accept, match, exp_acc, exp_code);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dec_valid !== 1'b0 || match !== 3'd0) begin
      fails++;
      $display("FAIL R1 reset outputs got v=%b code=%0d exp v=0 code=0", dec_valid, match);
    end
    send(48'h0, 1'b0, 3'd0, "R1 zero addr vs cleared slots");
    wr(5'd18, 32'h8);
    send(MC_LO, 1'b0, 3'd0, "R1 hash table cleared");

    wr(5'd0, 32'h0C0D_0E02); wr(5'd1, 32'h0000_0A0B);  // R3
    wr(5'd6, 32'h0000_0005); wr(5'd7, 32'h0000_0000);
    wr(5'd16, 32'h2); wr(5'd17, 32'h2);                // R6
    wr(5'd18, 32'h8);                                  // R7 hash enable

    for (int i = 0; i < 8; i++)
      send(VEC[i][51:4], VEC[i][3], VEC[i][2:0], $sformatf("vector %0d", i));

    @(negedge clk);
    checks++;
    if (dec_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle cycle got v=%b exp v=0", dec_valid);
    end

    wr(5'd0, 32'h0C0D_0E02);
    send(STA, 1'b0, 3'd0, "R4 low write disables slot");
    wr(5'd1, 32'h0000_0A0B);
    send(STA, 1'b1, 3'd1, "R4 high write re-enables slot");
    send(MC_X, 1'b1, 3'd1, "R4 other slot unaffected");

    wr(5'd18, 32'hC);
    send(BC, 1'b0, 3'd0, "R9 broadcast rejected");
    wr(5'd18, 32'h6);
    send(MC_NO, 1'b1, 3'd2, "R8 all-multicast");
    send(BC, 1'b0, 3'd0, "R8 broadcast excluded from all-multicast");
    wr(5'd18, 32'h0);
    send(MC_LO, 1'b0, 3'd0, "R7 hash disabled");
    send(UC_X, 1'b0, 3'd0, "R7 unicast dropped");
    wr(5'd18, 32'h1);
    send(UC_X, 1'b1, 3'd4, "R10 promiscuous");
    send(STA, 1'b1, 3'd1, "R11 exact over promiscuous");
    send(BC, 1'b1, 3'd3, "R11 broadcast over promiscuous");
    wr(5'd18, 32'h5);
    send(BC, 1'b1, 3'd4, "R10 promiscuous takes rejected broadcast");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule